// File: doc/BRIEF.md
# Overcurrent Threshold Capture and Two-Cycle Trip Detector

This block belongs to the digital core of a synchronous step-down controller. Once the supply is reported good, it runs a single setup pass that fixes the overcurrent threshold. The threshold is taken as one third of a digitized drop across an external setting resistor and clamped to a legal window. Two flags override that value. A high-supply flag forces a fixed level. A no-resistor flag selects the largest legal level. The setup pass lasts a base time plus a term that grows with the chosen threshold, and it ends by raising `setup_done`, which downstream sequencers wait on.

After setup, the block checks the low-side current sense against the held threshold. It only looks while the low-side switch is on. Each `cyc_strobe` closes a switching cycle. A cycle counts as faulty if any qualifying sample in it exceeded the threshold. The strobe cycle's own sample is included. Two faulty cycles in a row produce a one-clock `oc_trip` pulse. All values are unsigned millivolt codes.

The setup sequencer has four states. `ST_OFF` waits for supply-good. `ST_CAPTURE` latches the threshold and the setup length for one clock. `ST_SETTLE` counts the setup length. `ST_ARMED` enables the detector. Its transitions are:
- power_seen: `ST_OFF` to `ST_CAPTURE`.
- begin_count: `ST_CAPTURE` to `ST_SETTLE`.
- count_done: `ST_SETTLE` to `ST_ARMED`.
- supply_lost: from any other state to `ST_OFF`.

Top module: `ocp_thr_guard`

## Requirements
- R1: After reset `thr_code`, `setup_done` and `oc_trip` are all 0.
- R2: Let E1 be the first clock edge at which `supply_ok` is sampled high. `setup_done` is first high after edge E1+L+1, which makes it L+2 edges in all. L = BASE_CYC + min((T*STEP_NUM)>>STEP_SHIFT, SPAN_CYC), where T is the captured threshold; the defaults are 550, 13, 6 and 100.
- R3: With both flags low, the captured threshold is floor(`drop_code`/3), clamped to the range 50..500.
- R4: The threshold is held until `supply_ok` falls and rises again. Changes on `drop_code` after capture, and the time spent in `ST_OFF`, leave `thr_code` unchanged.
- R5: With `no_resistor` high and `hi_supply` low at capture, the threshold is 500.
- R6: With `hi_supply` high at capture, the threshold is 400, whatever the other inputs are. If `hi_supply` goes high later while powered, `thr_code` becomes 400 on the next clock and stays there until the next power-up.
- R7: A sample counts as a fault only when `ls_on` is 1 and `sense_code` is strictly greater than `thr_code`. A high sense with `ls_on` low, or a sense equal to the threshold, counts as clean.
- R8: `oc_trip` is a one-clock pulse that appears the clock after the strobe closing the second consecutive faulty cycle. A clean cycle clears the count, and the count restarts from zero after each trip.
- R9: No fault is counted and no trip occurs before `setup_done`. `setup_done` falls one clock after `supply_ok` goes low, and the detector's count is cleared at the same time.
- R10: A qualifying fault sample that falls in the strobe cycle itself counts toward the cycle being closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Supply above undervoltage-lockout level |
| hi_supply | input | 1 | Supply above high-voltage switch-over level |
| no_resistor | input | 1 | No threshold-setting resistor fitted |
| drop_code | input | DROP_W (12) | Digitized setting-resistor drop, mV |
| ls_on | input | 1 | Low-side switch on window |
| cyc_strobe | input | 1 | Closes a switching cycle |
| sense_code | input | THR_W (10) | Low-side current-sense drop, mV |
| thr_code | output | THR_W (10) | Held overcurrent threshold, mV |
| setup_done | output | 1 | Setup finished; detector armed |
| oc_trip | output | 1 | Overcurrent trip pulse |

## Verification
Two things can happen on the same clock: a fault sample can arrive together with the `cyc_strobe` that closes its cycle. The bench produces this by raising `ls_on` with the sense one code above threshold on the strobe clock, while the earlier samples of that cycle are clean. The cycle must then count as faulty, so two such cycles in a row must produce a trip exactly one clock after the second strobe. A scoreboard queue holds the expected trip clock numbers and judges every trip against them, including any trip that should not have happened.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_SETTLE  = 2'd2,
        ST_ARMED   = 2'd3
    } setup_state_e;

endpackage

// File: rtl/ocp_thr_select.sv
module ocp_thr_select #(
    parameter int DROP_W     = 12,
    parameter int THR_W      = 10,
    parameter int MIN_THR    = 50,
    parameter int MAX_THR    = 500,
    parameter int HI_THR     = 400,
    parameter int BASE_CYC   = 550,
    parameter int SPAN_CYC   = 100,
    parameter int STEP_NUM   = 13,
    parameter int STEP_SHIFT = 6,
    parameter int LEN_W      = 10
) (
    input  logic [DROP_W-1:0] drop_code,
    input  logic              hi_supply,
    input  logic              no_resistor,
    output logic [THR_W-1:0]  thr_sel,
    output logic [LEN_W-1:0]  len_sel
);

    localparam int PROD_W = THR_W + 8;
    localparam logic [DROP_W-1:0] MIN_D  = DROP_W'(MIN_THR);
    localparam logic [DROP_W-1:0] MAX_D  = DROP_W'(MAX_THR);
    localparam logic [THR_W-1:0]  HI_T   = THR_W'(HI_THR);
    localparam logic [THR_W-1:0]  MAX_T  = THR_W'(MAX_THR);
    localparam logic [PROD_W-1:0] SPAN_P = PROD_W'(SPAN_CYC);
    localparam logic [PROD_W-1:0] NUM_P  = PROD_W'(STEP_NUM);
    localparam logic [LEN_W-1:0]  BASE_L = LEN_W'(BASE_CYC);

    logic [DROP_W-1:0] third;
    logic [DROP_W-1:0] clamped;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] step;
    logic [PROD_W-1:0] extra;

    // one third of the resistor drop, forced into the legal window
    always_comb begin
        third = drop_code / DROP_W'(3);
        if (third < MIN_D)
            clamped = MIN_D;
        else if (third > MAX_D)
            clamped = MAX_D;
        else
            clamped = third;
    end

    // fixed level wins over the missing-resistor fallback
    always_comb begin
        if (hi_supply)
            thr_sel = HI_T;
        else if (no_resistor)
            thr_sel = MAX_T;
        else
            thr_sel = THR_W'(clamped);
    end

    // setup length grows with the threshold, capped at base + span
    always_comb begin
        prod  = PROD_W'(thr_sel) * NUM_P;
        step  = prod >> STEP_SHIFT;
        extra = (step > SPAN_P) ? SPAN_P : step;
        len_sel = BASE_L + LEN_W'(extra);
    end

endmodule

// File: rtl/ocp_setup_seq.sv
module ocp_setup_seq
    import ocp_pkg::*;
#(
    parameter int THR_W   = 10,
    parameter int LEN_W   = 10,
    parameter int MIN_THR = 50,
    parameter int MAX_THR = 500,
    parameter int HI_THR  = 400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_ok,
    input  logic             hi_supply,
    input  logic [THR_W-1:0] thr_sel,
    input  logic [LEN_W-1:0] len_sel,
    output logic [THR_W-1:0] thr_q,
    output logic             setup_done
);

    localparam logic [THR_W-1:0] HI_T  = THR_W'(HI_THR);
    localparam logic [THR_W-1:0] MIN_T = THR_W'(MIN_THR);
    localparam logic [THR_W-1:0] MAX_T = THR_W'(MAX_THR);

    setup_state_e     state_q, state_d;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_OFF;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:     if (supply_ok) state_d = ST_CAPTURE;           // power_seen
            ST_CAPTURE: state_d = supply_ok ? ST_SETTLE : ST_OFF;      // begin_count
            ST_SETTLE: begin
                if (!supply_ok)
                    state_d = ST_OFF;                                  // supply_lost
                else if (cnt_q == len_q - LEN_W'(1))
                    state_d = ST_ARMED;                                // count_done
            end
            ST_ARMED:   if (!supply_ok) state_d = ST_OFF;              // supply_lost
            default:    state_d = ST_OFF;
        endcase
    end

    // threshold, setup length and counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q <= '0;
            len_q <= '0;
            cnt_q <= '0;
        end else begin
            unique case (state_q)
                ST_OFF: ;
                ST_CAPTURE: begin
                    thr_q <= thr_sel;
                    len_q <= len_sel;
                    cnt_q <= '0;
                end
                ST_SETTLE: begin
                    cnt_q <= cnt_q + LEN_W'(1);
                    if (hi_supply) thr_q <= HI_T;
                end
                ST_ARMED: begin
                    if (hi_supply) thr_q <= HI_T;
                end
                default: ;
            endcase
        end
    end

    always_comb setup_done = (state_q == ST_ARMED);

    p_thr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_CAPTURE && !hi_supply) |=> $stable(thr_q));

    p_thr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        setup_done |-> (thr_q >= MIN_T && thr_q <= MAX_T));

    p_hi_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_OFF && hi_supply) |=> (thr_q == HI_T));

    p_done_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !setup_done);

    p_done_after_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(setup_done) |-> $past(state_q == ST_SETTLE));

endmodule

// File: rtl/ocp_trip_detect.sv
module ocp_trip_detect #(
    parameter int THR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed,
    input  logic             ls_on,
    input  logic             cyc_strobe,
    input  logic [THR_W-1:0] sense_code,
    input  logic [THR_W-1:0] thr_code,
    output logic             oc_trip
);

    logic fault_now;
    logic fault_seen_q;
    logic pend_q;
    logic cycle_bad;

    always_comb begin
        fault_now = ls_on && (sense_code > thr_code);
        cycle_bad = fault_seen_q || fault_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_seen_q <= 1'b0;
            pend_q       <= 1'b0;
            oc_trip      <= 1'b0;
        end else if (!armed) begin
            fault_seen_q <= 1'b0;
            pend_q       <= 1'b0;
            oc_trip      <= 1'b0;
        end else begin
            oc_trip <= 1'b0;
            if (cyc_strobe) begin
                fault_seen_q <= 1'b0;
                if (cycle_bad) begin
                    if (pend_q) begin
                        oc_trip <= 1'b1;
                        pend_q  <= 1'b0;
                    end else begin
                        pend_q <= 1'b1;
                    end
                end else begin
                    pend_q <= 1'b0;
                end
            end else if (fault_now) begin
                fault_seen_q <= 1'b1;
            end
        end
    end

    p_trip_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        oc_trip |=> !oc_trip);

    p_trip_on_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        oc_trip |-> $past(cyc_strobe));

    p_trip_armed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        oc_trip |-> $past(armed));

    p_trip_after_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oc_trip) |-> $past(pend_q));

endmodule

// File: rtl/ocp_thr_guard.sv
module ocp_thr_guard #(
    parameter int DROP_W     = 12,
    parameter int THR_W      = 10,
    parameter int MIN_THR    = 50,
    parameter int MAX_THR    = 500,
    parameter int HI_THR     = 400,
    parameter int BASE_CYC   = 550,
    parameter int SPAN_CYC   = 100,
    parameter int STEP_NUM   = 13,
    parameter int STEP_SHIFT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              hi_supply,
    input  logic              no_resistor,
    input  logic [DROP_W-1:0] drop_code,
    input  logic              ls_on,
    input  logic              cyc_strobe,
    input  logic [THR_W-1:0]  sense_code,
    output logic [THR_W-1:0]  thr_code,
    output logic              setup_done,
    output logic              oc_trip
);

    localparam int LEN_W = $clog2(BASE_CYC + SPAN_CYC + 1);

    logic [THR_W-1:0] thr_sel;
    logic [LEN_W-1:0] len_sel;

    ocp_thr_select #(
        .DROP_W(DROP_W), .THR_W(THR_W), .MIN_THR(MIN_THR), .MAX_THR(MAX_THR),
        .HI_THR(HI_THR), .BASE_CYC(BASE_CYC), .SPAN_CYC(SPAN_CYC),
        .STEP_NUM(STEP_NUM), .STEP_SHIFT(STEP_SHIFT), .LEN_W(LEN_W)
    ) u_select (
        .drop_code  (drop_code),
        .hi_supply  (hi_supply),
        .no_resistor(no_resistor),
        .thr_sel    (thr_sel),
        .len_sel    (len_sel)
    );

    ocp_setup_seq #(
        .THR_W(THR_W), .LEN_W(LEN_W), .MIN_THR(MIN_THR),
        .MAX_THR(MAX_THR), .HI_THR(HI_THR)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .hi_supply (hi_supply),
        .thr_sel   (thr_sel),
        .len_sel   (len_sel),
        .thr_q     (thr_code),
        .setup_done(setup_done)
    );

    ocp_trip_detect #(
        .THR_W(THR_W)
    ) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .armed     (setup_done),
        .ls_on     (ls_on),
        .cyc_strobe(cyc_strobe),
        .sense_code(sense_code),
        .thr_code  (thr_code),
        .oc_trip   (oc_trip)
    );

endmodule

// File: tb/ocp_thr_guard_tb_top.sv
module ocp_thr_guard_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        supply_ok = 1'b0;
    logic        hi_supply = 1'b0;
    logic        no_resistor = 1'b0;
    logic [11:0] drop_code = '0;
    logic        ls_on = 1'b0;
    logic        cyc_strobe = 1'b0;
    logic [9:0]  sense_code = '0;
    logic [9:0]  thr_code;
    logic        setup_done;
    logic        oc_trip;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int exp_thr = 0;
    bit pend = 1'b0;
    bit mon_on = 1'b0;
    bit finished = 1'b0;
    int exp_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ocp_thr_guard dut_i (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .hi_supply(hi_supply),
        .no_resistor(no_resistor), .drop_code(drop_code), .ls_on(ls_on),
        .cyc_strobe(cyc_strobe), .sense_code(sense_code), .thr_code(thr_code),
        .setup_done(setup_done), .oc_trip(oc_trip)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int thr_of(int drop, bit hi, bit nr);
        int t;
        if (hi) return 400;
        if (nr) return 500;
        t = drop / 3;
        if (t < 50) t = 50;
        if (t > 500) t = 500;
        return t;
    endfunction

    function automatic int len_of(int t);
        int e;
        e = (t * 13) >>> 6;
        if (e > 100) e = 100;
        return 550 + e;
    endfunction

    // scoreboard monitor: every trip is matched against the expected clock
    always @(negedge clk) begin
        if (mon_on) begin
            while (exp_q.size() > 0 && exp_q[0] < cyc) begin
                check(1'b0, "R8 missed trip", 0, 1);
                void'(exp_q.pop_front());
            end
            if (exp_q.size() > 0 && exp_q[0] == cyc) begin
                check(oc_trip == 1'b1, "R8 trip timing", int'(oc_trip), 1);
                void'(exp_q.pop_front());
            end else if (oc_trip) begin
                check(1'b0, "R9 unexpected trip", 1, 0);
            end
        end
    end

    // driver: one switching cycle of four clocks; pushes the expected trip
    task automatic sw_cycle(input bit f_mid, input bit f_end, input bit ls_mid);
        bit bad;
        @(negedge clk);
        ls_on = ls_mid; cyc_strobe = 1'b0;
        sense_code = f_mid ? 10'(exp_thr + 20) : 10'(exp_thr - 20);
        @(negedge clk);
        sense_code = 10'(exp_thr);
        @(negedge clk);
        ls_on = 1'b1; cyc_strobe = 1'b1;
        sense_code = f_end ? 10'(exp_thr + 1) : 10'(exp_thr);
        bad = (f_mid && ls_mid) || f_end;
        if (bad) begin
            if (pend) begin
                exp_q.push_back(cyc + 1);
                pend = 1'b0;
            end else begin
                pend = 1'b1;
            end
        end else begin
            pend = 1'b0;
        end
        @(negedge clk);
        cyc_strobe = 1'b0; ls_on = 1'b0; sense_code = '0;
    endtask

    task automatic power_up(input int drop, input bit hi, input bit nr, input string req);
        int n = 0;
        int exp_len;
        bit early = 1'b0;
        @(negedge clk);
        drop_code = 12'(drop); hi_supply = hi; no_resistor = nr;
        supply_ok = 1'b1;
        exp_thr = thr_of(drop, hi, nr);
        exp_len = len_of(exp_thr);
        pend = 1'b0;
        while (!setup_done && n < 2000) begin
            @(negedge clk);
            n++;
            if (!setup_done) begin
                ls_on = 1'b1; sense_code = 10'd1023;
                cyc_strobe = (n % 3 == 0);
            end
            if (setup_done && n < exp_len + 2) early = 1'b1;
        end
        ls_on = 1'b0; cyc_strobe = 1'b0; sense_code = '0;
        check(n == exp_len + 2 && !early, "R2 setup length", n, exp_len + 2);
        check(int'(thr_code) == exp_thr, req, int'(thr_code), exp_thr);
    endtask

    task automatic power_down();
        int held;
        held = int'(thr_code);
        @(negedge clk);
        supply_ok = 1'b0;
        @(negedge clk);
        check(setup_done == 1'b0, "R9 done falls", int'(setup_done), 0);
        repeat (5) @(negedge clk);
        check(int'(thr_code) == held, "R4 held while off", int'(thr_code), held);
        pend = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=0", 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(thr_code == '0, "R1 thr reset", int'(thr_code), 0);
        check(setup_done == 1'b0, "R1 done reset", int'(setup_done), 0);
        check(oc_trip == 1'b0, "R1 trip reset", int'(oc_trip), 0);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R3: 600/3 = 200, faults during setup must not trip (R9)
        power_up(600, 1'b0, 1'b0, "R3 third of drop");

        // R4: a new drop after capture is ignored
        @(negedge clk); drop_code = 12'd1200;
        repeat (3) @(negedge clk);
        check(int'(thr_code) == 200, "R4 drop ignored", int'(thr_code), 200);

        // R8: two faulty cycles trip
        sw_cycle(1'b1, 1'b0, 1'b1);
        sw_cycle(1'b1, 1'b0, 1'b1);
        // R8: clean cycle clears the count
        sw_cycle(1'b1, 1'b0, 1'b1);
        sw_cycle(1'b0, 1'b0, 1'b1);
        sw_cycle(1'b1, 1'b0, 1'b1);
        sw_cycle(1'b1, 1'b0, 1'b1);
        // R8: count restarts after a trip
        sw_cycle(1'b1, 1'b0, 1'b1);
        sw_cycle(1'b1, 1'b0, 1'b1);
        sw_cycle(1'b1, 1'b0, 1'b1);
        sw_cycle(1'b1, 1'b0, 1'b1);
        // R10: fault only in the strobe cycle
        sw_cycle(1'b0, 1'b1, 1'b1);
        sw_cycle(1'b0, 1'b1, 1'b1);
        // R7: high sense with low side off, then a sense equal to threshold
        sw_cycle(1'b1, 1'b0, 1'b1);
        sw_cycle(1'b1, 1'b0, 1'b0);
        sw_cycle(1'b1, 1'b0, 1'b1);
        sw_cycle(1'b0, 1'b0, 1'b1);
        sw_cycle(1'b1, 1'b0, 1'b1);
        sw_cycle(1'b1, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R8 all trips seen", exp_q.size(), 0);

        // R6: high supply while armed switches to fixed level, sticky
        @(negedge clk); hi_supply = 1'b1;
        @(negedge clk);
        check(int'(thr_code) == 400, "R6 switch to fixed", int'(thr_code), 400);
        hi_supply = 1'b0;
        repeat (2) @(negedge clk);
        check(int'(thr_code) == 400, "R6 fixed sticky", int'(thr_code), 400);
        exp_thr = 400;
        sw_cycle(1'b1, 1'b0, 1'b1);
        sw_cycle(1'b1, 1'b0, 1'b1);
        sw_cycle(1'b0, 1'b1, 1'b0);
        sw_cycle(1'b0, 1'b1, 1'b0);

        // R5: missing resistor picks the maximum
        power_down();
        power_up(300, 1'b0, 1'b1, "R5 no resistor max");
        // R3: low clamp
        power_down();
        power_up(90, 1'b0, 1'b0, "R3 low clamp");
        // R3: high clamp
        power_down();
        power_up(3000, 1'b0, 1'b0, "R3 high clamp");
        // R6: fixed level wins over missing resistor
        power_down();
        power_up(900, 1'b1, 1'b1, "R6 fixed priority");
        sw_cycle(1'b1, 1'b0, 1'b1);
        sw_cycle(1'b1, 1'b0, 1'b1);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R8 final queue empty", exp_q.size(), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule